// File: doc/BRIEF.md
# Condition Register Field-Move Unit

This unit keeps a 32-bit condition register made of eight 4-bit fields and updates it with two move-to-register operations. A 64-bit source operand, an 8-bit field mask, an operation select and a valid strobe come in. Every accepted operation is answered one cycle later by a single-cycle completion pulse. The register contents can be read at all times.

The masked-merge form widens each mask bit into a 4-bit group. It then takes the low 32 source bits wherever the widened mask is set and keeps the old register bits everywhere else. The single-field form copies exactly one field. It is legal only when the mask has exactly one bit set. An illegal mask leaves the register alone and raises an error pulse.

The one-hot test works by passing the mask through a priority picker. The picker keeps only the highest-priority set bit, and the mask counts as one-hot when the picker output equals the mask and the mask is nonzero. Decode, register-file access and hazard handling are done outside the unit.

Top module: `crf_move_unit`

## Requirements
- R1: A synchronous active-high reset clears the condition register, the done pulse and the error pulse to zero.
- R2: In merge mode (`op_sel`=0), mask bit 7 governs register bits 31:28, mask bit 6 governs bits 27:24, and so on down to mask bit 0 for bits 3:0. The new register equals (src[31:0] AND widened mask) OR (old register AND NOT widened mask). A mask of 0xF1 widens to 0xFFFF000F.
- R3: In merge mode, a mask of 0x00 leaves the register unchanged, and a mask of 0xFF loads src[31:0] in full.
- R4: In single-field mode (`op_sel`=1) with a one-hot mask, only the nibble chosen by the set mask bit (same bit-to-nibble mapping as R2) receives the matching source nibble. The other seven nibbles keep their values.
- R5: In single-field mode with a mask that is zero or has two or more bits set, the register keeps its value and `op_err` is 1 in the cycle that `op_done` is 1.
- R6: `mask_onehot` follows `fld_mask` combinationally and is 1 exactly when one mask bit is set.
- R7: `op_done` is 1 for exactly the one cycle after each clock edge at which `op_valid` was 1. When `op_valid` is 0, the register holds its value and `op_done` and `op_err` stay 0.
- R8: Source bits 63:32 never affect the register.
- R9: In merge mode, `op_err` stays 0 for every mask value, including masks that are not one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 1 | 0 = masked merge, 1 = single field |
| src_val | input | 64 | Source operand; only bits 31:0 are used |
| fld_mask | input | 8 | Field mask; bit 7 maps to the top nibble |
| cr_value | output | 32 | Current condition register |
| mask_onehot | output | 1 | Field mask has exactly one bit set |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Single-field operation rejected |

## Verification
The assertions run on every cycle. They check that the register is held on idle cycles, that completion is a one-cycle pulse tied to the strobe, and that an illegal single-field mask leaves the register untouched and raises the error. They also check that the picker-based one-hot flag agrees with a plain bit count, and that error only ever comes with done. Only the bench's scenarios can show the actual data movement. That covers the nibble ordering of the widened mask, the 0xF1 corner, which nibble a single-field move changes, and that the upper source half is ignored. For these the bench compares the register against a reference model under random and directed operations.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int unsigned FIELDS  = 8;
    localparam int unsigned FIELD_W = 4;
    localparam int unsigned SRC_W   = 64;
    localparam int unsigned CR_W    = FIELDS * FIELD_W;

    typedef enum logic {
        OP_MERGE  = 1'b0,
        OP_SINGLE = 1'b1
    } crf_op_e;

    typedef struct packed {
        logic          valid;
        crf_op_e       op;
        logic [CR_W-1:0] data;
        logic [FIELDS-1:0] mask;
    } crf_req_t;

    typedef struct packed {
        logic            write;
        logic            err;
        logic [CR_W-1:0] next_cr;
    } crf_upd_t;

    // Bitwise select: take a where sel is set, b elsewhere.
    function automatic logic [CR_W-1:0] crf_blend(
        input logic [CR_W-1:0] a,
        input logic [CR_W-1:0] b,
        input logic [CR_W-1:0] sel
    );
        return (a & sel) | (b & ~sel);
    endfunction

endpackage

// File: rtl/crf_mask_widen.sv
module crf_mask_widen #(
    parameter int unsigned FIELDS  = crf_pkg::FIELDS,
    parameter int unsigned FIELD_W = crf_pkg::FIELD_W,
    localparam int unsigned OUT_W  = FIELDS * FIELD_W
) (
    input  logic [FIELDS-1:0] mask_in,
    output logic [OUT_W-1:0]  mask_out
);
    // Each mask bit drives the nibble at the same relative position.
    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        assign mask_out[f*FIELD_W +: FIELD_W] = {FIELD_W{mask_in[f]}};
    end
endmodule

// File: rtl/crf_prio_pick.sv
module crf_prio_pick #(
    parameter int unsigned WIDTH = crf_pkg::FIELDS
) (
    input  logic [WIDTH-1:0] req,
    output logic [WIDTH-1:0] grant
);
    // The highest-index bit (top field) has the highest priority.
    logic [WIDTH:0] above;

    assign above[WIDTH] = 1'b0;

    for (genvar i = WIDTH; i > 0; i--) begin : g_chain
        assign grant[i-1] = req[i-1] & ~above[i];
        assign above[i-1] = above[i] | req[i-1];
    end
endmodule

// File: rtl/crf_onehot_check.sv
module crf_onehot_check #(
    parameter int unsigned WIDTH = crf_pkg::FIELDS
) (
    input  logic [WIDTH-1:0] vec,
    output logic [WIDTH-1:0] picked,
    output logic             is_onehot
);
    crf_prio_pick #(.WIDTH(WIDTH)) u_pick (
        .req   (vec),
        .grant (picked)
    );

    assign is_onehot = (picked == vec) && (|vec);
endmodule

// File: rtl/crf_move_unit.sv
module crf_move_unit
    import crf_pkg::*;
#(
    parameter int unsigned N_FIELDS = crf_pkg::FIELDS,
    parameter int unsigned F_WIDTH  = crf_pkg::FIELD_W,
    parameter int unsigned SRC_BITS = crf_pkg::SRC_W,
    localparam int unsigned REG_W   = N_FIELDS * F_WIDTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    input  logic                op_sel,
    input  logic [SRC_BITS-1:0] src_val,
    input  logic [N_FIELDS-1:0] fld_mask,
    output logic [REG_W-1:0]    cr_value,
    output logic                mask_onehot,
    output logic                op_done,
    output logic                op_err
);
    crf_req_t req;
    crf_upd_t upd;

    logic [REG_W-1:0]    wide_mask;
    logic [N_FIELDS-1:0] picked_mask;
    logic                oh;

    logic [REG_W-1:0] cr_q;
    logic             done_q;
    logic             err_q;

    always_comb begin
        req.valid = op_valid;
        req.op    = crf_op_e'(op_sel);
        req.data  = src_val[REG_W-1:0];
        req.mask  = fld_mask;
    end

    crf_mask_widen #(
        .FIELDS  (N_FIELDS),
        .FIELD_W (F_WIDTH)
    ) u_widen (
        .mask_in  (req.mask),
        .mask_out (wide_mask)
    );

    crf_onehot_check #(.WIDTH(N_FIELDS)) u_oh (
        .vec       (req.mask),
        .picked    (picked_mask),
        .is_onehot (oh)
    );

    // Update decision: a single-field move goes through the same blend
    // as a merge once the mask is proven to have one bit set.
    always_comb begin
        upd.write   = 1'b0;
        upd.err     = 1'b0;
        upd.next_cr = cr_q;
        if (req.valid) begin
            unique case (req.op)
                OP_MERGE: begin
                    upd.write   = 1'b1;
                    upd.next_cr = crf_blend(req.data, cr_q, wide_mask);
                end
                OP_SINGLE: begin
                    if (oh) begin
                        upd.write   = 1'b1;
                        upd.next_cr = crf_blend(req.data, cr_q, wide_mask);
                    end else begin
                        upd.err = 1'b1;
                    end
                end
                default: upd.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cr_q   <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (upd.write) begin
                cr_q <= upd.next_cr;
            end
            done_q <= req.valid;
            err_q  <= upd.err;
        end
    end

    assign cr_value    = cr_q;
    assign mask_onehot = oh;
    assign op_done     = done_q;
    assign op_err      = err_q;

    logic unused_bits;
    assign unused_bits = ^{src_val[SRC_BITS-1:REG_W], picked_mask};
endmodule

// File: rtl/crf_move_chk.sv
module crf_move_chk #(
    parameter int unsigned N_FIELDS = 8,
    parameter int unsigned SRC_BITS = 64,
    parameter int unsigned REG_W    = 32
) (
    input logic                clk,
    input logic                rst,
    input logic                op_valid,
    input logic                op_sel,
    input logic [SRC_BITS-1:0] src_val,
    input logic [N_FIELDS-1:0] fld_mask,
    input logic [REG_W-1:0]    cr_value,
    input logic                mask_onehot,
    input logic                op_done,
    input logic                op_err
);
    logic unused_src;
    assign unused_src = ^src_val;

    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (cr_value == '0 && !op_done && !op_err));

    assert_onehot_count_R6: assert property (@(posedge clk) disable iff (rst)
        mask_onehot == ($countones(fld_mask) == 1));

    assert_done_follows_R7: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> op_done);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!op_done && !op_err && $stable(cr_value)));

    assert_bad_single_R5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel && !mask_onehot) |=> (op_err && $stable(cr_value)));

    assert_merge_no_err_R9: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_sel) |=> !op_err);

    assert_err_with_done_R5: assert property (@(posedge clk) disable iff (rst)
        op_err |-> op_done);
endmodule

bind crf_move_unit crf_move_chk #(
    .N_FIELDS (N_FIELDS),
    .SRC_BITS (SRC_BITS),
    .REG_W    (REG_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .op_valid    (op_valid),
    .op_sel      (op_sel),
    .src_val     (src_val),
    .fld_mask    (fld_mask),
    .cr_value    (cr_value),
    .mask_onehot (mask_onehot),
    .op_done     (op_done),
    .op_err      (op_err)
);

// File: tb/crf_move_unit_test.sv
module crf_move_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic        op_sel;
    logic [63:0] src_val;
    logic [7:0]  fld_mask;
    logic [31:0] cr_value;
    logic        mask_onehot;
    logic        op_done;
    logic        op_err;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_cr;

    always #2 clk = ~clk;

    crf_move_unit uut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .src_val(src_val), .fld_mask(fld_mask), .cr_value(cr_value),
        .mask_onehot(mask_onehot), .op_done(op_done), .op_err(op_err)
    );

    function automatic logic [31:0] widen(input logic [7:0] m);
        logic [31:0] r = '0;
        for (int k = 0; k < 8; k++)
            if (m[k]) r[k*4 +: 4] = 4'hF;
        return r;
    endfunction

    function automatic logic single_bit(input logic [7:0] m);
        int n = 0;
        for (int k = 0; k < 8; k++) n += m[k];
        return n == 1;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check results at the next falling edge.
    task automatic step(input logic v, input logic s, input logic [63:0] src,
                        input logic [7:0] m, input string tag);
        logic exp_err;
        op_valid = v; op_sel = s; src_val = src; fld_mask = m;
        #1;
        check("R6 onehot flag", {63'd0, mask_onehot}, {63'd0, single_bit(m)});
        exp_err = 1'b0;
        if (v) begin
            if (!s || single_bit(m))
                model_cr = (src[31:0] & widen(m)) | (model_cr & ~widen(m));
            else
                exp_err = 1'b1;
        end
        @(negedge clk);
        check({tag, " register"}, {32'd0, cr_value}, {32'd0, model_cr});
        check("R7 done pulse", {63'd0, op_done}, {63'd0, v});
        check({tag, " error"}, {63'd0, op_err}, {63'd0, exp_err});
    endtask

    initial begin
        #100000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0435));
        rst = 1'b1; op_valid = 0; op_sel = 0; src_val = '0; fld_mask = '0;
        model_cr = '0;
        repeat (3) @(negedge clk);
        check("R1 reset register", {32'd0, cr_value}, 64'd0);
        check("R1 reset done", {63'd0, op_done}, 64'd0);
        check("R1 reset error", {63'd0, op_err}, 64'd0);
        rst = 1'b0;

        // R2 0xF1 widening shows up as a merge of all-ones into zero.
        step(1, 0, 64'hDEAD_BEEF_FFFF_FFFF, 8'hF1, "R2 merge F1");
        check("R2 F1 pattern", {32'd0, cr_value}, 64'h0000_0000_FFFF_000F);
        // R3 corner masks
        step(1, 0, 64'h1234_5678_9ABC_DEF0, 8'hFF, "R3 full mask");
        step(1, 0, 64'hFFFF_FFFF_0000_0000, 8'h00, "R3 empty mask");
        check("R3 empty keeps", {32'd0, cr_value}, 64'h0000_0000_9ABC_DEF0);
        // R4 single field, top and bottom nibble
        step(1, 1, 64'h0000_0000_5000_0000, 8'h80, "R4 single top");
        check("R4 top nibble", {32'd0, cr_value}, 64'h0000_0000_5ABC_DEF0);
        step(1, 1, 64'h0000_0000_FFFF_FFF3, 8'h01, "R4 single low");
        check("R4 low nibble", {32'd0, cr_value}, 64'h0000_0000_5ABC_DEF3);
        // R5 illegal single masks
        step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h00, "R5 zero mask");
        step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 8'h81, "R5 two bits");
        step(1, 1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R5 all bits");
        // R9 merge with non-one-hot mask never errors
        step(1, 0, 64'h0, 8'h3C, "R9 merge multi");
        // R7 idle cycles hold
        step(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R7 idle");
        step(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, "R7 idle");
        // R8 upper half ignored
        step(1, 0, 64'hAAAA_AAAA_0000_0000, 8'hFF, "R8 upper ignored");
        check("R8 zero loaded", {32'd0, cr_value}, 64'd0);

        for (int i = 0; i < 400; i++) begin
            logic [7:0] m;
            logic s;
            s = 1'($urandom);
            m = 8'($urandom);
            if (s && ($urandom % 2 == 0)) m = 8'h1 << ($urandom % 8);
            step(($urandom % 5) != 0, s, {$urandom, $urandom}, m,
                 s ? "R4 random single" : "R2 random merge");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule